// File: doc/BRIEF.md
# System Reset Generator

This block gathers every source that can restart a chip and turns them into two reset outputs. The power-on reset is the deepest one. It follows a supply-low indication from the analog monitor and reaches every register in the chip, including the groups that must survive an ordinary restart: debug logic, flash key state, the real-time clock, the power controller and part of the clock controller. The system reset restarts everything else. It is raised by the power-on reset, a watchdog expiry, a processor lockup, a software reset request, or an external reset pad held low.

Each internal cause is stretched by a down-counter on a reference clock, so that even a one-cycle request gives a system reset of a guaranteed minimum width. The default is 320 cycles of a 16 MHz reference, which is 20 µs. While the stretched pulse runs, the block pulls the open-drain reset pad low so that the rest of the board can see that an internal reset happened.

The pad is read back through a two-flop synchroniser. Whatever is read while the block itself drives the pad, or while the synchroniser still holds that drive, is ignored. A lockup is ignored while a debugger is attached. A sticky cause register records which sources have fired since it was last cleared.

Top module: `sys_reset_gen`

## Requirements
- R1: `por_rst_n` is low while `supply_low` is high, and it rises on the second rising clock edge after `supply_low` falls.
- R2: `sys_rst_n` is low whenever `por_rst_n` is low, whenever an internal cause is being stretched, and whenever the synchronised external pad request is active.
- R3: While `dbg_attached` is 1, `cpu_lockup` has no effect: `sys_rst_n` stays high, `pad_drive_low` stays low and cause bit 2 is not set.
- R4: An internal cause (`wdg_expire`, `sw_rst_req`, or `cpu_lockup` without a debugger) that is sampled on N consecutive edges holds `sys_rst_n` low for exactly PULSE_CYC+N-1 cycles, starting after the first of those edges. After the power-on reset is released, `sys_rst_n` stays low for PULSE_CYC more cycles.
- R5: A low level on `pad_in` that is not caused by the block holds `sys_rst_n` low for as many cycles as the pad stays low, two cycles later because of the synchroniser.
- R6: `pad_drive_low` is 1 exactly while an internal cause is being stretched, and never for an external pad request. The block's own pad drive never counts as an external request.
- R7: Once released, `por_rst_n` stays high while `supply_low` is low, whatever the system reset causes do.
- R8: `rst_cause` bits are: 0 power-on, 1 watchdog, 2 lockup, 3 software, 4 external pad. A bit is set on the edge after its event and held until `cause_clr` is sampled high. An event in the same cycle as the clear wins. The power-on reset loads the value 5'b00001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, nominally 16 MHz |
| supply_low | input | 1 | Supply-below-threshold indication from the analog monitor, active high, asynchronous |
| wdg_expire | input | 1 | Watchdog expiry request |
| cpu_lockup | input | 1 | Processor lockup indication |
| dbg_attached | input | 1 | Debugger connected; masks the lockup cause |
| sw_rst_req | input | 1 | Software or debugger system reset request |
| pad_in | input | 1 | Level read back from the external reset pad, active low |
| cause_clr | input | 1 | Clears the cause register |
| por_rst_n | output | 1 | Power-on reset for the groups that survive a system reset, active low |
| sys_rst_n | output | 1 | System reset, active low |
| pad_drive_low | output | 1 | Open-drain enable that pulls the reset pad low |
| rst_cause | output | 5 | Sticky record of the reset sources |

## Verification
If the stretch counter loads or counts wrongly, the low time of `sys_rst_n` is off by cycles. That shows up at the first internal cause, as soon as the pulse ends. A mask window that is too short lets the block's own pad drive echo back. That shows up two cycles after the stretch ends, as an extra low stretch on `sys_rst_n` and a spurious pad bit in `rst_cause`. A broken sticky or clear path in the cause register shows up on the first edge after an event or a clear. The bench compares all four outputs against a behavioural model on every cycle, so each of these faults is reported in the cycle it first reaches a port.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

  localparam int CAUSE_W = 5;
  localparam int CB_POR  = 0;
  localparam int CB_WDG  = 1;
  localparam int CB_LOCK = 2;
  localparam int CB_SW   = 3;
  localparam int CB_PAD  = 4;

  localparam logic [CAUSE_W-1:0] CAUSE_AT_POR = 5'b00001;

  // Next value of a stretch counter: reload on request, otherwise count down to zero.
  function automatic int unsigned stretch_next(input int unsigned cur,
                                               input logic load,
                                               input int unsigned full);
    if (load)
      return full;
    else if (cur != 0)
      return cur - 1;
    else
      return 0;
  endfunction

  // Sticky merge of new events into the cause record.
  function automatic logic [CAUSE_W-1:0] cause_merge(input logic [CAUSE_W-1:0] old,
                                                     input logic clr,
                                                     input logic [CAUSE_W-1:0] ev);
    return (clr ? '0 : old) | ev;
  endfunction

endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)
      sh_q <= {STAGES{RST_VAL}};
    else
      sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/rstgen_stretch.sv
module rstgen_stretch
  import rstgen_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 320
) (
  input  logic clk,
  input  logic arst,
  input  logic hold,
  input  logic trig,
  output logic active
);

  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PULSE_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             load;

  assign load  = hold | trig;
  assign cnt_d = CNT_W'(stretch_next(32'(cnt_q), load, PULSE_CYC));

  always_ff @(posedge clk or posedge arst) begin
    if (arst)
      cnt_q <= CNT_FULL;
    else
      cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);

  AST_STRETCH_LOAD: assert property (@(posedge clk) disable iff (arst)
    trig |=> (cnt_q == CNT_FULL)); // R4

  AST_STRETCH_HELD: assert property (@(posedge clk) disable iff (arst)
    (active && !trig && !hold) |=> (cnt_q < CNT_FULL)); // R4

endmodule

// File: rtl/rstgen_cause.sv
module rstgen_cause
  import rstgen_pkg::*;
(
  input  logic               clk,
  input  logic               arst,
  input  logic               clr,
  input  logic [CAUSE_W-1:0] ev,
  output logic [CAUSE_W-1:0] cause
);

  logic [CAUSE_W-1:0] cause_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)
      cause_q <= CAUSE_AT_POR;
    else
      cause_q <= cause_merge(cause_q, clr, ev);
  end

  assign cause = cause_q;

  AST_CAUSE_CLEAR: assert property (@(posedge clk) disable iff (arst)
    (clr && (ev == '0)) |=> (cause_q == '0)); // R8

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (arst)
    !clr |=> ((cause_q & $past(cause_q)) == $past(cause_q))); // R8

  AST_CAUSE_WDG: assert property (@(posedge clk) disable iff (arst)
    ev[CB_WDG] |=> cause_q[CB_WDG]); // R8

endmodule

// File: rtl/sys_reset_gen.sv
module sys_reset_gen
  import rstgen_pkg::*;
#(
  parameter int unsigned PULSE_CYC   = 320,
  parameter int          SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               supply_low,
  input  logic               wdg_expire,
  input  logic               cpu_lockup,
  input  logic               dbg_attached,
  input  logic               sw_rst_req,
  input  logic               pad_in,
  input  logic               cause_clr,
  output logic               por_rst_n,
  output logic               sys_rst_n,
  output logic               pad_drive_low,
  output logic [CAUSE_W-1:0] rst_cause
);

  // Named internal events
  logic                   lock_eff;
  logic                   int_trig;
  logic                   pad_sync;
  logic                   pad_echo_mask;
  logic                   pad_seen;
  logic                   stretch_on;
  logic [SYNC_STAGES-1:0] drv_hist_q;
  logic [CAUSE_W-1:0]     cause_ev;

  // Power-on reset: asynchronous assert, synchronised release
  rstgen_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_por_sync (
    .clk  (clk),
    .arst (supply_low),
    .d    (1'b1),
    .q    (por_rst_n)
  );

  // External pad readback, idle high
  rstgen_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pad_sync (
    .clk  (clk),
    .arst (supply_low),
    .d    (pad_in),
    .q    (pad_sync)
  );

  assign lock_eff = cpu_lockup & ~dbg_attached;
  assign int_trig = wdg_expire | sw_rst_req | lock_eff;

  rstgen_stretch #(.PULSE_CYC(PULSE_CYC)) u_stretch (
    .clk    (clk),
    .arst   (supply_low),
    .hold   (~por_rst_n),
    .trig   (int_trig),
    .active (stretch_on)
  );

  // History of the block's own drive, as long as the synchroniser latency
  always_ff @(posedge clk or posedge supply_low) begin
    if (supply_low)
      drv_hist_q <= '1;
    else
      drv_hist_q <= {drv_hist_q[SYNC_STAGES-2:0], stretch_on};
  end

  assign pad_echo_mask = stretch_on | (|drv_hist_q);
  assign pad_seen      = ~pad_sync & ~pad_echo_mask;

  assign pad_drive_low = stretch_on;
  assign sys_rst_n     = por_rst_n & ~stretch_on & ~pad_seen;

  always_comb begin
    cause_ev          = '0;
    cause_ev[CB_POR]  = ~por_rst_n;
    cause_ev[CB_WDG]  = wdg_expire;
    cause_ev[CB_LOCK] = lock_eff;
    cause_ev[CB_SW]   = sw_rst_req;
    cause_ev[CB_PAD]  = pad_seen;
  end

  rstgen_cause u_cause (
    .clk   (clk),
    .arst  (supply_low),
    .clr   (cause_clr),
    .ev    (cause_ev),
    .cause (rst_cause)
  );

  AST_LOCK_MASKED: assert property (@(posedge clk) disable iff (supply_low)
    $rose(rst_cause[CB_LOCK]) |-> $past(!dbg_attached)); // R3

  AST_INT_RESETS: assert property (@(posedge clk) disable iff (supply_low)
    int_trig |=> !sys_rst_n); // R2

  AST_PAD_NOT_ECHO: assert property (@(posedge clk) disable iff (supply_low)
    $rose(rst_cause[CB_PAD]) |-> !$past(pad_drive_low)); // R6

  AST_POR_STAYS: assert property (@(posedge clk) disable iff (supply_low)
    por_rst_n |=> por_rst_n); // R7

endmodule

// File: tb/test_sys_reset_gen.sv
`timescale 1ns/1ps
module test_sys_reset_gen;

  localparam int P = 320;

  logic clk = 1'b0;
  logic supply_low = 1'b1;
  logic wdg_expire = 1'b0;
  logic cpu_lockup = 1'b0;
  logic dbg_attached = 1'b0;
  logic sw_rst_req = 1'b0;
  logic ext_pad_low = 1'b0;
  logic cause_clr = 1'b0;
  logic pad_in;
  logic por_rst_n, sys_rst_n, pad_drive_low;
  logic [4:0] rst_cause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit run_cmp = 1'b0;

  always #10 clk = ~clk;

  // Open-drain pad: low if the board or the block pulls it
  assign pad_in = ~(ext_pad_low | pad_drive_low);

  sys_reset_gen #(.PULSE_CYC(P)) i_sys_reset_gen (
    .clk(clk), .supply_low(supply_low), .wdg_expire(wdg_expire),
    .cpu_lockup(cpu_lockup), .dbg_attached(dbg_attached), .sw_rst_req(sw_rst_req),
    .pad_in(pad_in), .cause_clr(cause_clr), .por_rst_n(por_rst_n),
    .sys_rst_n(sys_rst_n), .pad_drive_low(pad_drive_low), .rst_cause(rst_cause)
  );

  // Behavioural reference model
  int m_por_edges;
  int m_left;
  bit m_pad_q[$];
  bit m_own_hist[$];
  logic [4:0] m_cause;
  bit t_por_ok, t_drv, t_preq, t_lock;

  function automatic bit mdl_pad_req();
    return (m_pad_q[1] == 1'b0) && !(m_left > 0) && !m_own_hist[0] && !m_own_hist[1];
  endfunction

  always @(posedge clk or posedge supply_low) begin
    if (supply_low) begin
      m_por_edges = 0;
      m_left = P;
      m_pad_q = '{1'b1, 1'b1};
      m_own_hist = '{1'b1, 1'b1};
      m_cause = 5'b00001;
    end else begin
      t_por_ok = (m_por_edges >= 2);
      t_drv = (m_left > 0);
      t_preq = mdl_pad_req();
      t_lock = cpu_lockup && !dbg_attached;
      m_cause = (cause_clr ? 5'b0 : m_cause) |
                {t_preq, sw_rst_req, t_lock, wdg_expire, !t_por_ok};
      if (!t_por_ok || wdg_expire || sw_rst_req || t_lock) m_left = P;
      else if (m_left > 0) m_left = m_left - 1;
      m_own_hist.push_front(t_drv);
      void'(m_own_hist.pop_back());
      m_pad_q.push_front(pad_in);
      void'(m_pad_q.pop_back());
      if (m_por_edges < 2) m_por_edges++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp && !done) begin
      chk(por_rst_n === (m_por_edges >= 2), "R1 por_rst_n", por_rst_n, m_por_edges >= 2);
      chk(sys_rst_n === ((m_por_edges >= 2) && !(m_left > 0) && !mdl_pad_req()),
          "R2 sys_rst_n", sys_rst_n, (m_por_edges >= 2) && !(m_left > 0) && !mdl_pad_req());
      chk(pad_drive_low === (m_left > 0), "R6 pad_drive_low", pad_drive_low, m_left > 0);
      chk(rst_cause === m_cause, "R8 rst_cause", rst_cause, m_cause);
    end
  end

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic set_src(input int id, input logic v);
    case (id)
      0: wdg_expire = v;
      1: sw_rst_req = v;
      2: cpu_lockup = v;
      default: ext_pad_low = v;
    endcase
  endtask

  task automatic clear_cause();
    cause_clr = 1'b1;
    step();
    cause_clr = 1'b0;
  endtask

  task automatic run_cause(input int id, input int hold, input int window,
                           output int lows, output int drvs, output int por_lows);
    lows = 0; drvs = 0; por_lows = 0;
    set_src(id, 1'b1);
    for (int i = 0; i < window; i++) begin
      @(negedge clk);
      if (!sys_rst_n) lows++;
      if (pad_drive_low) drvs++;
      if (!por_rst_n) por_lows++;
      step();
      if (i == hold - 1) set_src(id, 1'b0);
    end
  endtask

  int lows, drvs, plows;

  initial begin
    run_cmp = 1'b1;
    repeat (3) step();
    // R1: reset state during supply-low
    chk(por_rst_n === 1'b0, "R1 por low in supply-low", por_rst_n, 0);
    chk(sys_rst_n === 1'b0, "R2 sys low in supply-low", sys_rst_n, 0);
    chk(rst_cause === 5'b00001, "R8 cause at power-on", rst_cause, 1);
    supply_low = 1'b0;
    // R4: release stretch after power-on
    lows = 0;
    for (int i = 0; i < P + 20; i++) begin
      @(negedge clk);
      if (!sys_rst_n && por_rst_n) lows++;
      step();
    end
    chk(lows == P, "R4 stretch after power-on", lows, P);
    chk(por_rst_n === 1'b1, "R1 por released", por_rst_n, 1);

    clear_cause();
    @(negedge clk);
    chk(rst_cause === 5'b00000, "R8 cause cleared", rst_cause, 0);
    step();

    // Watchdog one-cycle request
    run_cause(0, 1, P + 20, lows, drvs, plows);
    chk(lows == P, "R4 watchdog width", lows, P);
    chk(drvs == P, "R6 pad drive width", drvs, P);
    chk(plows == 0, "R7 por untouched by watchdog", plows, 0);
    chk(rst_cause === 5'b00010, "R8 watchdog cause", rst_cause, 2);
    clear_cause();

    // Lockup with debugger attached: masked
    dbg_attached = 1'b1;
    run_cause(2, 30, 40, lows, drvs, plows);
    chk(lows == 0, "R3 lockup masked sys", lows, 0);
    chk(drvs == 0, "R3 lockup masked pad", drvs, 0);
    chk(rst_cause[2] === 1'b0, "R3 lockup masked cause", rst_cause[2], 0);
    dbg_attached = 1'b0;
    clear_cause();

    // Lockup without debugger, held five cycles
    run_cause(2, 5, P + 20, lows, drvs, plows);
    chk(lows == P + 4, "R4 lockup held width", lows, P + 4);
    chk(rst_cause === 5'b00100, "R8 lockup cause", rst_cause, 4);
    clear_cause();

    // Software request
    run_cause(1, 1, P + 20, lows, drvs, plows);
    chk(lows == P, "R2 software reset width", lows, P);
    chk(plows == 0, "R7 por untouched by software", plows, 0);
    chk(rst_cause === 5'b01000, "R8 software cause", rst_cause, 8);
    clear_cause();

    // External pad held low for 40 cycles
    run_cause(3, 40, 80, lows, drvs, plows);
    chk(lows == 40, "R5 pad hold width", lows, 40);
    chk(drvs == 0, "R6 no drive for pad cause", drvs, 0);
    chk(rst_cause === 5'b10000, "R8 pad cause", rst_cause, 16);

    // Event in the same cycle as clear wins
    cause_clr = 1'b1;
    wdg_expire = 1'b1;
    step();
    cause_clr = 1'b0;
    wdg_expire = 1'b0;
    @(negedge clk);
    chk(rst_cause === 5'b00010, "R8 event beats clear", rst_cause, 2);
    repeat (P + 5) step();

    // Supply dip reloads the power-on cause
    supply_low = 1'b1;
    repeat (2) step();
    supply_low = 1'b0;
    repeat (P + 5) step();
    @(negedge clk);
    chk(rst_cause === 5'b00001, "R8 cause after supply dip", rst_cause, 1);
    chk(sys_rst_n === 1'b1, "R2 sys released after dip", sys_rst_n, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule